// File: doc/BRIEF.md
# RTC Status Flags and Time Access Control

This block holds the single 8-bit status and control register of a real-time clock. Three event flags record a watchdog expiry, an alarm match and a power-fail detection. Each stays set until software reads the register. A fourth flag records that the oscillator was not running at start-up. That flag is sticky: only a software write of 0 removes it. The remaining bits are plain read/write controls.

The control bits govern how software reaches the user time registers. The read-freeze bit stops the counters from refreshing the user registers, so that a multi-byte time read is consistent. The write-freeze bit does the same and also opens the time registers for writes. When software clears the write-freeze bit after changing the time, the block pulses a load strobe that copies the user registers into the timekeeping counters. A calibration bit replaces the interrupt output with a 512 Hz square wave. The wave is derived from a 32.768 kHz enable.

Top module: `rtc_flag_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and int_o follows irq_i, freeze_o is 0 and load_o is 0.
- R2: A one-cycle pulse on wdt_evt_i, alarm_evt_i or pfail_evt_i sets bit 7, bit 6 or bit 5 respectively, and the bit reads 1 from the next cycle on.
- R3: A register read (sel_i and rd_i) returns the current bits on rdata_o in the same cycle, then clears bits 7..5 from the next cycle on. Bit 4 is left unchanged by the read.
- R4: When an event arrives in the same cycle as a clearing read, its flag stays set.
- R5: A pulse on osc_fail_i sets bit 4. A register write with wdata_i[4]=0 clears it, and a write with wdata_i[4]=1 leaves it unchanged.
- R6: Writes do not change bits 7..5, and bit 3 always reads 0.
- R7: With bit 2 (calibration) set to 1, int_o carries a square wave that starts low and toggles after every 32 cycles of cal_tick_i, which gives 512 Hz from 32.768 kHz. With bit 2 at 0, int_o equals irq_i.
- R8: freeze_o is 1 while bit 1 (write-freeze) or bit 0 (read-freeze) is 1, and bit 0 can be set while bit 1 is 0.
- R9: When a write clears bit 1 after at least one time_wr_i pulse arrived while bit 1 was 1, load_o is high for exactly one cycle, in the cycle after that write. The modified state is then cleared.
- R10: A time_wr_i pulse while bit 1 is 0 does not mark the time modified, so clearing bit 1 later gives no load_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdt_evt_i | input | 1 | Watchdog expiry event |
| alarm_evt_i | input | 1 | Alarm match event |
| pfail_evt_i | input | 1 | Power-fail detect event |
| osc_fail_i | input | 1 | Oscillator not running at start-up |
| sel_i | input | 1 | Register selected |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register contents |
| time_wr_i | input | 1 | Write to a user time register |
| cal_tick_i | input | 1 | 32.768 kHz enable |
| irq_i | input | 1 | Normal interrupt request |
| int_o | output | 1 | Interrupt or calibration wave |
| freeze_o | output | 1 | Hold user time registers |
| load_o | output | 1 | Copy user time into counters |

## Verification
A flag that is stuck, or that clears on the wrong event, shows on rdata_o one cycle after the stimulus. The read that would clear it shows the old value in the same cycle. A modified tracker that is wrong shows up only when write-freeze falls: a missing or extra load_o appears in the cycle after the clearing write. A divider phase error shifts the first int_o edge away from exactly the 32nd tick. That error can be seen within one half period.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_WDT   = 7;
  localparam int unsigned B_ALM   = 6;
  localparam int unsigned B_PF    = 5;
  localparam int unsigned B_OSC   = 4;
  localparam int unsigned B_CAL   = 2;
  localparam int unsigned B_WEN   = 1;
  localparam int unsigned B_REN   = 0;
  localparam int unsigned N_EVT   = 3;
endpackage

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (evt_i)  flag_q <= 1'b1;  // event wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_evt_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> flag_o);
  p_rd_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !evt_i) |=> !flag_o);
endmodule

// File: rtl/rtc_cal_div.sv
module rtc_cal_div #(
  parameter int unsigned DIV_RATIO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic sq_o
);
  localparam int unsigned HALF = DIV_RATIO / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          sq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        sq_q  <= ~sq_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sq_o = sq_q;

  p_cal_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sq_o);
  p_no_tick_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(sq_o));
endmodule

// File: rtl/rtc_hold_ctrl.sv
module rtc_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wen_i,
  input  logic ren_i,
  input  logic time_wr_i,
  input  logic wen_clr_i,
  output logic freeze_o,
  output logic load_o
);
  logic mod_q, load_q, mod_set;

  assign mod_set = time_wr_i & wen_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q  <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_q <= wen_clr_i & (mod_q | mod_set);
      if (wen_clr_i)    mod_q <= 1'b0;
      else if (mod_set) mod_q <= 1'b1;
    end
  end

  assign freeze_o = wen_i | ren_i;
  assign load_o   = load_q;

  p_load_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  p_load_on_wen_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (!wen_i && $past(wen_i)));
endmodule

// File: rtl/rtc_flag_ctrl.sv
module rtc_flag_ctrl
  import rtc_flag_pkg::*;
#(
  parameter int unsigned CAL_DIV = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdt_evt_i,
  input  logic             alarm_evt_i,
  input  logic             pfail_evt_i,
  input  logic             osc_fail_i,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic             time_wr_i,
  input  logic             cal_tick_i,
  input  logic             irq_i,
  output logic             int_o,
  output logic             freeze_o,
  output logic             load_o
);
  logic [N_EVT-1:0] evt_in, evt_q;
  logic             rd_hit, wr_hit, wen_clr;
  logic             osc_q, cal_q, wen_q, ren_q, sq;

  assign rd_hit = sel_i & rd_i;
  assign wr_hit = sel_i & wr_i;
  assign evt_in = {wdt_evt_i, alarm_evt_i, pfail_evt_i};

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    rtc_evt_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .evt_i (evt_in[g]),
      .clr_i (rd_hit),
      .flag_o(evt_q[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= 1'b0;
      cal_q <= 1'b0;
      wen_q <= 1'b0;
      ren_q <= 1'b0;
    end else begin
      if (osc_fail_i)                      osc_q <= 1'b1;
      else if (wr_hit && !wdata_i[B_OSC])  osc_q <= 1'b0;
      if (wr_hit) begin
        cal_q <= wdata_i[B_CAL];
        wen_q <= wdata_i[B_WEN];
        ren_q <= wdata_i[B_REN];
      end
    end
  end

  assign wen_clr = wr_hit & wen_q & ~wdata_i[B_WEN];

  rtc_hold_ctrl u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wen_i    (wen_q),
    .ren_i    (ren_q),
    .time_wr_i(time_wr_i),
    .wen_clr_i(wen_clr),
    .freeze_o (freeze_o),
    .load_o   (load_o)
  );

  rtc_cal_div #(.DIV_RATIO(CAL_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cal_q),
    .tick_i(cal_tick_i),
    .sq_o  (sq)
  );

  assign int_o   = cal_q ? sq : irq_i;
  assign rdata_o = {evt_q, osc_q, 1'b0, cal_q, wen_q, ren_q};

  p_osc_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[B_OSC] && !(wr_hit && !wdata_i[B_OSC])) |=> rdata_o[B_OSC]);
  p_evt_wr_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !rd_hit && !(|evt_in)) |=> $stable(rdata_o[7:5]));
  p_bit3_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[3]);
endmodule

// File: tb/rtc_flag_ctrl_test.sv
module rtc_flag_ctrl_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wdt = 0, alm = 0, pf = 0, osc = 0;
  logic       sel = 0, rd = 0, wr = 0, twr = 0, tick = 0, irq = 0;
  logic [7:0] wdata = '0, rdata;
  logic       int_s, frz, ld;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  rtc_flag_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wdt_evt_i(wdt), .alarm_evt_i(alm),
    .pfail_evt_i(pf), .osc_fail_i(osc), .sel_i(sel), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .time_wr_i(twr), .cal_tick_i(tick),
    .irq_i(irq), .int_o(int_s), .freeze_o(frz), .load_o(ld));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_rd(output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; #1 d = rdata;
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic t_reset();
    irq = 1; #1;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 int", {7'b0, int_s}, 8'h01);
    chk("R1 freeze/load", {6'b0, frz, ld}, 8'h00);
    irq = 0;
  endtask

  task automatic t_events();
    logic [7:0] d;
    @(negedge clk); wdt = 1; pf = 1;
    @(negedge clk); wdt = 0; pf = 0;
    chk("R2 wdt+pf set", rdata, 8'hA0);
    bus_rd(d);
    chk("R3 read returns", d, 8'hA0);
    chk("R3 cleared after read", rdata, 8'h00);
    @(negedge clk); alm = 1;
    @(negedge clk); alm = 0;
    chk("R2 alarm set", rdata, 8'h40);
    bus_rd(d);
  endtask

  task automatic t_priority();
    @(negedge clk); alm = 1; sel = 1; rd = 1;
    @(negedge clk); alm = 0; sel = 0; rd = 0;
    chk("R4 event beats read", rdata, 8'h40);
    @(negedge clk); sel = 1; rd = 1;
    @(negedge clk); sel = 0; rd = 0;
    chk("R4 later read clears", rdata, 8'h00);
  endtask

  task automatic t_osc();
    logic [7:0] d;
    @(negedge clk); osc = 1;
    @(negedge clk); osc = 0;
    chk("R5 osc set", rdata, 8'h10);
    bus_rd(d);
    chk("R5 osc survives read", rdata, 8'h10);
    bus_wr(8'h10);
    chk("R5 write 1 keeps osc", rdata, 8'h10);
    bus_wr(8'h00);
    chk("R5 write 0 clears osc", rdata, 8'h00);
  endtask

  task automatic t_wr_mask();
    logic [7:0] d;
    @(negedge clk); wdt = 1;
    @(negedge clk); wdt = 0;
    bus_wr(8'hE8);
    chk("R6 writes ignore 7..5 and 3", rdata, 8'h80);
    bus_rd(d);
    chk("R6 bit3 reads 0", {7'b0, rdata[3]}, 8'h00);
  endtask

  task automatic t_cal();
    irq = 1; #1;
    chk("R7 int follows irq", {7'b0, int_s}, 8'h01);
    bus_wr(8'h04);
    chk("R7 wave starts low", {7'b0, int_s}, 8'h00);
    for (int i = 0; i < 31; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    end
    chk("R7 low after 31 ticks", {7'b0, int_s}, 8'h00);
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    chk("R7 high after 32 ticks", {7'b0, int_s}, 8'h01);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); tick = 1; @(negedge clk); tick = 0;
    end
    chk("R7 low after 64 ticks", {7'b0, int_s}, 8'h00);
    bus_wr(8'h00); irq = 0; #1;
    chk("R7 cal off int follows irq", {7'b0, int_s}, 8'h00);
  endtask

  task automatic t_freeze();
    bus_wr(8'h01);
    chk("R8 read-freeze alone", {7'b0, frz}, 8'h01);
    bus_wr(8'h02);
    chk("R8 write-freeze", {7'b0, frz}, 8'h01);
    bus_wr(8'h00);
    chk("R8 no freeze", {7'b0, frz}, 8'h00);
  endtask

  task automatic t_load();
    int pulses;
    // R10: time write while not frozen
    @(negedge clk); twr = 1; @(negedge clk); twr = 0;
    bus_wr(8'h02);
    bus_wr(8'h00);
    chk("R10 no load without modification", {7'b0, ld}, 8'h00);
    // R9: modification under write-freeze
    bus_wr(8'h02);
    @(negedge clk); twr = 1; @(negedge clk); twr = 0;
    @(negedge clk); sel = 1; wr = 1; wdata = 8'h00;
    #1 chk("R9 no load before clear", {7'b0, ld}, 8'h00);
    @(negedge clk); sel = 0; wr = 0;
    chk("R9 load pulse", {7'b0, ld}, 8'h01);
    pulses = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); pulses += ld; end
    chk("R9 load one cycle", 8'(pulses), 8'h00);
    bus_wr(8'h02);
    bus_wr(8'h00);
    chk("R9 tracker cleared", {7'b0, ld}, 8'h00);
  endtask

  initial begin
    #10000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog timeout");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_events();
    t_priority();
    t_osc();
    t_wr_mask();
    t_cal();
    t_freeze();
    t_load();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule